// File: doc/BRIEF.md
# Capture and Reset Event Counter

This block counts rising edges on an external count input. It samples the input in the system clock domain. The count is held as two chained halves: a low counter, and an overflow counter that advances in the same cycle the low half wraps. Together they read as one wide count on `count_o`.

Two further external strobes act on the count, and both are handled entirely in hardware:
- A capture strobe copies both halves at once into a holding register and flags that a snapshot is waiting.
- A zero strobe clears both halves.

A count edge that lands in the same cycle as either strobe is still counted. An acknowledge input, already in the system domain, clears the pending flag. A second capture that arrives before the acknowledge raises an overrun flag.

Every external input passes through a two-flop synchronizer and a rising-edge detector. The system clock must therefore run at least four times faster than the count input. For example, a 6.5 MHz count needs a system clock of 26 MHz or more.

Top module: `evt_capture_counter`

## Requirements
- R1: While `rst_ni` is low and just after it rises, `count_o`, `snap_o`, `snap_valid_o` and `overrun_o` are all zero.
- R2: Each of `cnt_i`, `cap_i` and `zero_i` goes through two synchronizer flops and a rising-edge detector. Each low-to-high transition of `cnt_i` that is held for at least one clock period adds exactly one to the count, however long the level stays high. The change appears on `count_o` after the third rising clock edge that follows the transition.
- R3: `count_o` is `{high, low}`, with the low half in the LOW_W least significant bits. When the low half wraps from all ones to zero, the high half increments in that same clock cycle.
- R4: When the whole count is all ones and one more edge arrives, the count wraps to zero.
- R5: A detected rising edge on `zero_i` clears both halves to zero.
- R6: If a count edge and a zero edge are detected in the same cycle, the count becomes 1.
- R7: A detected rising edge on `cap_i` loads `snap_o` with the count as it stood before that cycle's update, and sets `snap_valid_o`. At all other times `snap_o` holds its value.
- R8: If a capture edge and a zero edge are detected in the same cycle, `snap_o` takes the value from before the clear.
- R9: When `ack_i` is high at a clock edge, it clears `snap_valid_o` and `overrun_o`. A capture that arrives while `snap_valid_o` is set and `ack_i` is low sets `overrun_o`. A capture in the same cycle as `ack_i` leaves `snap_valid_o` at 1 and `overrun_o` at 0.
- R10: A count edge detected in the same cycle as a capture edge is still added to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 1 | External count input; rising edges are counted |
| cap_i | input | 1 | Capture strobe; acts on its rising edge |
| zero_i | input | 1 | Clear strobe; acts on its rising edge |
| ack_i | input | 1 | Acknowledge, system domain; clears the pending and overrun flags |
| count_o | output | LOW_W+HIGH_W | Live count, `{high, low}` |
| snap_o | output | LOW_W+HIGH_W | Last captured count |
| snap_valid_o | output | 1 | A snapshot is waiting to be acknowledged |
| overrun_o | output | 1 | A capture arrived before the previous one was acknowledged |

## Verification
Three events can be detected in the same system cycle: a count edge, a clear, and a capture. The bench provokes each pairing by raising the relevant inputs on the same falling clock edge. Because all three share one synchronizer depth, their pulses coincide.

The outcome is judged in two ways:
- A behavioural model, fed the same input history, is compared with every output on every clock.
- Directed checks confirm the hand-computed results: 1 after count plus clear, the pre-clear value after capture plus clear, and the incremented count after count plus capture.

The acknowledge is also placed in the capture's update cycle, to exercise the flag priority.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  parameter int unsigned DEF_LOW_W  = 16;
  parameter int unsigned DEF_HIGH_W = 16;
  parameter int unsigned DEF_SYNC_N = 2;

  typedef struct packed {
    logic cnt;
    logic cap;
    logic zero;
  } strobe_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], async_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise_o = sync_q[SYNC_N-1] & ~prev_q;

  // one pulse per transition
  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/split_counter.sv
module split_counter #(
  parameter int unsigned LOW_W  = 16,
  parameter int unsigned HIGH_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    inc_i,
  input  logic                    clr_i,
  output logic [LOW_W+HIGH_W-1:0] count_o
);
  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;
  logic              carry;

  assign carry = inc_i & (&low_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (clr_i) begin
      // keep a coincident edge
      low_q  <= LOW_W'(inc_i);
      high_q <= '0;
    end else begin
      if (inc_i) low_q  <= low_q + 1'b1;
      if (carry) high_q <= high_q + 1'b1;
    end
  end

  assign count_o = {high_q, low_q};

  p_carry_same_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && (&low_q)) |=> (low_q == '0) && (high_q == HIGH_W'($past(high_q) + 1'b1)));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inc_i) |=> (count_o == '0));
  p_clear_keep_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && inc_i) |=> (high_q == '0) && (low_q == LOW_W'(1)));
  p_no_lost_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (count_o != $past(count_o)));
endmodule

// File: rtl/snap_hold.sv
module snap_hold #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         ack_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] snap_o,
  output logic         valid_o,
  output logic         overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (cap_i) snap_o <= live_i;
      valid_o   <= cap_i | (valid_o & ~ack_i);
      overrun_o <= ~ack_i & (overrun_o | (cap_i & valid_o));
    end
  end

  p_snap_takes_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> valid_o && (snap_o == $past(live_i)));
  p_snap_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(snap_o));
  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && valid_o && !ack_i) |=> overrun_o);
  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !cap_i) |=> !valid_o && !overrun_o);
endmodule

// File: rtl/evt_capture_counter.sv
module evt_capture_counter
  import evt_cnt_pkg::*;
#(
  parameter int unsigned LOW_W  = DEF_LOW_W,
  parameter int unsigned HIGH_W = DEF_HIGH_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cnt_i,
  input  logic                    cap_i,
  input  logic                    zero_i,
  input  logic                    ack_i,
  output logic [LOW_W+HIGH_W-1:0] count_o,
  output logic [LOW_W+HIGH_W-1:0] snap_o,
  output logic                    snap_valid_o,
  output logic                    overrun_o
);
  localparam int unsigned CW = LOW_W + HIGH_W;
  localparam int unsigned NS = $bits(strobe_t);

  strobe_t         raw, rise;
  logic [NS-1:0]   raw_v, rise_v;
  logic [CW-1:0]   live;

  assign raw.cnt  = cnt_i;
  assign raw.cap  = cap_i;
  assign raw.zero = zero_i;
  assign raw_v    = raw;
  assign rise     = rise_v;

  for (genvar g = 0; g < NS; g++) begin : g_sync
    edge_sync #(.SYNC_N(SYNC_N)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(raw_v[g]),
      .rise_o (rise_v[g])
    );
  end

  split_counter #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (rise.cnt),
    .clr_i  (rise.zero),
    .count_o(live)
  );

  snap_hold #(.W(CW)) u_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (rise.cap),
    .ack_i    (ack_i),
    .live_i   (live),
    .snap_o   (snap_o),
    .valid_o  (snap_valid_o),
    .overrun_o(overrun_o)
  );

  assign count_o = live;

  // snapshot taken alongside a clear sees the old count
  p_cap_before_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise.cap && rise.zero) |=> (snap_o == $past(live)));
endmodule

// File: tb/evt_capture_counter_tb.sv
module evt_capture_counter_tb;
  localparam int LW = 4;
  localparam int HW = 4;
  localparam int CW = LW + HW;
  localparam int MOD = 1 << CW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cnt_i = 1'b0, cap_i = 1'b0, zero_i = 1'b0, ack_i = 1'b0;
  logic [CW-1:0] count_o, snap_o;
  logic snap_valid_o, overrun_o;

  int checks = 0;
  int errors = 0;
  int exp_total = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  evt_capture_counter #(.LOW_W(LW), .HIGH_W(HW), .SYNC_N(2)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_i), .cap_i(cap_i),
    .zero_i(zero_i), .ack_i(ack_i), .count_o(count_o), .snap_o(snap_o),
    .snap_valid_o(snap_valid_o), .overrun_o(overrun_o));

  // behavioural model: input history per edge, integer count
  bit h_cnt[$], h_cap[$], h_zero[$];
  int m_count = 0, m_snap = 0;
  bit m_valid = 0, m_ovr = 0;

  task automatic hist_reset();
    h_cnt = '{0, 0, 0}; h_cap = '{0, 0, 0}; h_zero = '{0, 0, 0};
  endtask

  initial hist_reset();

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_reset();
      m_count = 0; m_snap = 0; m_valid = 0; m_ovr = 0;
    end else begin
      bit c, p, z;
      int nc;
      c = h_cnt[1] && !h_cnt[2];
      p = h_cap[1] && !h_cap[2];
      z = h_zero[1] && !h_zero[2];
      nc = z ? (c ? 1 : 0) : (c ? (m_count + 1) % MOD : m_count);
      if (p) m_snap = m_count;
      m_ovr   = !ack_i && (m_ovr || (p && m_valid));
      m_valid = p || (m_valid && !ack_i);
      m_count = nc;
      h_cnt.push_front(cnt_i);   void'(h_cnt.pop_back());
      h_cap.push_front(cap_i);   void'(h_cap.pop_back());
      h_zero.push_front(zero_i); void'(h_zero.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && !done) begin
    chk("model count R2", count_o, m_count);
    chk("model snap R7", snap_o, m_snap);
    chk("model valid R9", snap_valid_o, m_valid);
    chk("model overrun R9", overrun_o, m_ovr);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic count_edges(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); cnt_i = 1'b1;
      idle(2); cnt_i = 1'b0;
      idle(1);
    end
    exp_total = (exp_total + n) % MOD;
  endtask

  task automatic strobe(bit c, bit p, bit z);
    @(negedge clk_i);
    if (c) cnt_i = 1'b1;
    if (p) cap_i = 1'b1;
    if (z) zero_i = 1'b1;
    idle(2);
    cnt_i = 1'b0; cap_i = 1'b0; zero_i = 1'b0;
    idle(5);
  endtask

  task automatic ack();
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0;
  endtask

  initial begin
    idle(2);
    chk("R1 count in reset", count_o, 0);
    chk("R1 valid in reset", snap_valid_o, 0);
    rst_ni = 1'b1;
    idle(1);
    chk("R1 count after reset", count_o, 0);
    chk("R1 snap after reset", snap_o, 0);
    chk("R1 overrun after reset", overrun_o, 0);

    // latency: rise at negedge, visible after third posedge
    @(negedge clk_i); cnt_i = 1'b1;
    idle(2); chk("R2 not yet counted", count_o, 0);
    idle(1); chk("R2 counted on third edge", count_o, 1);
    idle(6); chk("R2 long high counts once", count_o, 1);
    cnt_i = 1'b0; idle(2);
    exp_total = 1;

    count_edges(19);
    idle(4);
    chk("R2 twenty edges", count_o, 20);
    chk("R3 high half after wrap", count_o >> LW, 1);
    chk("R3 low half after wrap", count_o & ((1 << LW) - 1), 4);

    strobe(0, 1, 0);
    chk("R7 snapshot value", snap_o, 20);
    chk("R7 valid set", snap_valid_o, 1);
    ack();
    idle(1);
    chk("R9 ack clears valid", snap_valid_o, 0);

    strobe(0, 1, 0);
    strobe(0, 1, 0);
    chk("R9 overrun on second capture", overrun_o, 1);
    ack();
    idle(1);
    chk("R9 ack clears overrun", overrun_o, 0);

    // capture and ack land in the same update cycle
    @(negedge clk_i); cap_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0; cap_i = 1'b0;
    idle(3);
    chk("R9 capture beats ack valid", snap_valid_o, 1);
    chk("R9 capture with ack no overrun", overrun_o, 0);
    ack();

    strobe(0, 0, 1);
    exp_total = 0;
    chk("R5 clear", count_o, 0);

    count_edges(7);
    strobe(1, 0, 1);
    exp_total = 1;
    chk("R6 clear keeps coincident edge", count_o, 1);

    count_edges(5);
    strobe(0, 1, 1);
    chk("R8 snapshot before clear", snap_o, 6);
    chk("R8 count cleared", count_o, 0);
    exp_total = 0;
    ack();

    count_edges(3);
    strobe(1, 1, 0);
    exp_total = 4;
    chk("R10 edge kept with capture", count_o, 4);
    chk("R10 snapshot pre-edge", snap_o, 3);
    ack();

    count_edges(MOD - 5);
    idle(4);
    chk("R4 one below full", count_o, MOD - 1);
    count_edges(1);
    idle(4);
    chk("R4 full wrap", count_o, 0);
    chk("R4 bench tally", count_o, exp_total);

    idle(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule